// File: doc/BRIEF.md
# Video Interrupt Level Controller

This block produces the 3-bit interrupt priority level that a video display processor presents to its host CPU. There are two sources. A per-line horizontal strobe raises a raster-line request. The same strobe, when it arrives on the vertical blanking line, raises a blanking request and sets a status occurrence flag. Each source has an enable bit, written through a small register-write port. The block resolves priority between the two sources and drives the level output.

Masking a source hides its request but does not drop it. A request is removed only when the CPU acknowledges it. The acknowledge input carries the level being serviced. Every change of the computed level reaches the output only after a fixed latency. During that time the CPU can read the status flag, or finish the instruction it is executing, before the new level is seen.

One ordering case is handled on purpose. The CPU may acknowledge the raster-line level after the blanking request has already been armed toward it. In that case both requests are consumed, and the blanking occurrence is lost.

Top module: `vid_irq_ctrl`

## Requirements
- R1: Enables are stored only from writes to address 0 bit 4 (horizontal) and address 1 bit 5 (vertical). Writes to any other address, and all other bits, leave the level output unchanged.
- R2: A horizontal strobe sets the horizontal pending flag. When that flag is set and the horizontal enable is 1, the computed level is 4.
- R3: A horizontal strobe while `line_num` equals VBL_LINE (224) sets the vertical pending flag, and sets `vint_flag` on the next clock edge, whatever the vertical enable is. When the vertical flag is pending and the vertical enable is 1, the computed level is 6.
- R4: When both sources are pending and enabled, the computed level is 6.
- R5: When no source is both pending and enabled, the level output returns to 0.
- R6: Clearing an enable bit never clears a pending flag. Setting the enable bit again while the request is still pending raises the level again.
- R7: An acknowledge with `ack_lvl` = 6 clears the vertical pending flag and `vint_flag` on the next edge. It leaves the horizontal request untouched.
- R8: An acknowledge with `ack_lvl` = 4 clears only the horizontal pending flag, provided no vertical request is armed. A vertical request is armed once it has been pending while its enable is 1.
- R9: An acknowledge with `ack_lvl` = 4 while a vertical request is armed clears the horizontal pending flag. It also drops the vertical pending flag and `vint_flag`.
- R10: A change of the computed level appears on `irq_lvl` exactly LAT_CYCLES+1 clock edges after the edge that registered its cause. A further change of the computed level before then restarts the wait.
- R11: Reset (asynchronous assertion, synchronous release) clears both pending flags, both enables, `vint_flag` and the latency counter, and forces `irq_lvl` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register address |
| reg_data | input | DATA_W (8) | Register write data |
| h_evt | input | 1 | One-cycle per-line horizontal event strobe |
| line_num | input | LINE_W (9) | Current line number, sampled with `h_evt` |
| ack_vld | input | 1 | Interrupt acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| irq_lvl | output | 3 | Delayed interrupt priority level (0, 4 or 6) |
| vint_flag | output | 1 | Vertical interrupt occurrence status flag |

## Verification
The level is driven through several patterns, and each one separates a different mistake. A request raised while masked shows whether masking is mistaken for clearing. Both sources pending shows whether priority is inverted. Writes with every other bit set, or to a foreign address, show whether the decode is wrong. Acknowledges are tested at each level, both with the vertical request armed and without it, which separates normal servicing from the dropped-occurrence case. The output is also sampled one cycle before and one cycle after the expected latency, and again across a quick off/on toggle, to catch an off-by-one count and a missing restart.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  typedef logic [2:0] irq_lvl_t;
  localparam irq_lvl_t LVL_NONE = 3'd0;
  localparam irq_lvl_t LVL_HOR  = 3'd4;
  localparam irq_lvl_t LVL_VER  = 3'd6;
  localparam int unsigned HEN_ADDR = 0;
  localparam int unsigned HEN_BIT  = 4;
  localparam int unsigned VEN_ADDR = 1;
  localparam int unsigned VEN_BIT  = 5;
endpackage

// File: rtl/vid_irq_enables.sv
module vid_irq_enables
  import vid_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_data,
  output logic              h_en,
  output logic              v_en
);
  logic h_en_n, v_en_n;
  logic h_sel, v_sel;

  always_comb begin
    h_sel  = reg_wr && (reg_addr == ADDR_W'(HEN_ADDR));
    v_sel  = reg_wr && (reg_addr == ADDR_W'(VEN_ADDR));
    h_en_n = h_sel ? reg_data[HEN_BIT] : h_en;
    v_en_n = v_sel ? reg_data[VEN_BIT] : v_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_en <= 1'b0;
      v_en <= 1'b0;
    end else begin
      if (h_sel) h_en <= h_en_n;
      if (v_sel) v_en <= v_en_n;
    end
  end
endmodule

// File: rtl/vid_irq_sources.sv
module vid_irq_sources
  import vid_irq_pkg::*;
#(
  parameter int LINE_W   = 9,
  parameter int VBL_LINE = 224
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_evt,
  input  logic [LINE_W-1:0] line_num,
  input  logic              ack_vld,
  input  irq_lvl_t          ack_lvl,
  input  logic              v_en,
  output logic              h_pend,
  output logic              v_pend,
  output logic              v_armed,
  output logic              stat_flag
);
  logic set_h, set_v, ack_h, ack_v, drop_v;
  logic h_pend_n, v_pend_n, v_armed_n, stat_n;
  logic upd_en;

  always_comb begin
    set_h  = h_evt;
    set_v  = h_evt && (line_num == LINE_W'(VBL_LINE));
    ack_h  = ack_vld && (ack_lvl == LVL_HOR);
    ack_v  = ack_vld && (ack_lvl == LVL_VER);
    // a late horizontal acknowledge swallows an armed vertical request
    drop_v = ack_v || (ack_h && v_armed);

    h_pend_n  = set_h || (h_pend && !ack_h);
    v_pend_n  = set_v || (v_pend && !drop_v);
    stat_n    = set_v || (stat_flag && !drop_v);
    v_armed_n = drop_v ? 1'b0 : (v_armed || (v_pend && v_en));
    upd_en    = set_h || set_v || ack_h || ack_v || (v_pend && v_en && !v_armed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_pend    <= 1'b0;
      v_pend    <= 1'b0;
      v_armed   <= 1'b0;
      stat_flag <= 1'b0;
    end else if (upd_en) begin
      h_pend    <= h_pend_n;
      v_pend    <= v_pend_n;
      v_armed   <= v_armed_n;
      stat_flag <= stat_n;
    end
  end
endmodule

// File: rtl/vid_irq_prio.sv
module vid_irq_prio
  import vid_irq_pkg::*;
(
  input  logic     h_pend,
  input  logic     h_en,
  input  logic     v_pend,
  input  logic     v_en,
  output irq_lvl_t tgt_lvl
);
  always_comb begin
    if (v_pend && v_en)      tgt_lvl = LVL_VER;
    else if (h_pend && h_en) tgt_lvl = LVL_HOR;
    else                     tgt_lvl = LVL_NONE;
  end
endmodule

// File: rtl/vid_irq_delay.sv
module vid_irq_delay
  import vid_irq_pkg::*;
#(
  parameter int LAT_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  irq_lvl_t tgt_lvl,
  output irq_lvl_t out_lvl
);
  localparam int CNT_W = $clog2(LAT_CYCLES + 1);

  irq_lvl_t           held_q, held_n, out_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               chg, upd_en;

  always_comb begin
    chg    = (tgt_lvl != held_q);
    held_n = held_q;
    cnt_n  = cnt_q;
    out_n  = out_lvl;
    if (chg) begin
      held_n = tgt_lvl;
      cnt_n  = CNT_W'(LAT_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) out_n = held_q;
    end
    upd_en = chg || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= LVL_NONE;
      cnt_q   <= '0;
      out_lvl <= LVL_NONE;
    end else if (upd_en) begin
      held_q  <= held_n;
      cnt_q   <= cnt_n;
      out_lvl <= out_n;
    end
  end
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
  import vid_irq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int LINE_W     = 9,
  parameter int VBL_LINE   = 224,
  parameter int LAT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_data,
  input  logic              h_evt,
  input  logic [LINE_W-1:0] line_num,
  input  logic              ack_vld,
  input  logic [2:0]        ack_lvl,
  output logic [2:0]        irq_lvl,
  output logic              vint_flag
);
  logic     rst_s1, rst_sync_n;
  logic     h_en, v_en, h_pend, v_pend, v_armed;
  irq_lvl_t tgt_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  vid_irq_enables #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_data(reg_data), .h_en(h_en), .v_en(v_en));

  vid_irq_sources #(.LINE_W(LINE_W), .VBL_LINE(VBL_LINE)) u_src (
    .clk(clk), .rst_n(rst_sync_n), .h_evt(h_evt), .line_num(line_num),
    .ack_vld(ack_vld), .ack_lvl(ack_lvl), .v_en(v_en), .h_pend(h_pend),
    .v_pend(v_pend), .v_armed(v_armed), .stat_flag(vint_flag));

  vid_irq_prio u_prio (
    .h_pend(h_pend), .h_en(h_en), .v_pend(v_pend), .v_en(v_en),
    .tgt_lvl(tgt_lvl));

  vid_irq_delay #(.LAT_CYCLES(LAT_CYCLES)) u_dly (
    .clk(clk), .rst_n(rst_sync_n), .tgt_lvl(tgt_lvl), .out_lvl(irq_lvl));
endmodule

// File: rtl/vid_irq_chk.sv
module vid_irq_chk #(
  parameter int LINE_W     = 9,
  parameter int VBL_LINE   = 224,
  parameter int LAT_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_evt,
  input logic [LINE_W-1:0] line_num,
  input logic              ack_vld,
  input logic [2:0]        ack_lvl,
  input logic [2:0]        irq_lvl,
  input logic              vint_flag,
  input logic [2:0]        tgt_lvl,
  input logic              h_pend
);
  localparam int SW = $clog2(LAT_CYCLES + 2);
  logic [SW-1:0] since;
  logic [2:0]    tgt_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since    <= SW'(LAT_CYCLES);
      tgt_prev <= 3'd0;
    end else begin
      tgt_prev <= tgt_lvl;
      if (tgt_lvl != tgt_prev)           since <= '0;
      else if (since < SW'(LAT_CYCLES)) since <= since + 1'b1;
    end
  end

  // R4
  lvl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl == 3'd0) || (irq_lvl == 3'd4) || (irq_lvl == 3'd6));

  // R3
  vflag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_evt && line_num == LINE_W'(VBL_LINE)) |=> vint_flag);

  // R7
  vflag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && ack_lvl == 3'd6 && !(h_evt && line_num == LINE_W'(VBL_LINE))) |=> !vint_flag);

  // R6
  hpend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_pend && !(ack_vld && ack_lvl == 3'd4)) |=> h_pend);

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl != $past(irq_lvl)) |-> (since == SW'(LAT_CYCLES) && irq_lvl == tgt_lvl));
endmodule

bind vid_irq_ctrl vid_irq_chk #(.LINE_W(LINE_W), .VBL_LINE(VBL_LINE), .LAT_CYCLES(LAT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .h_evt(h_evt), .line_num(line_num),
  .ack_vld(ack_vld), .ack_lvl(ack_lvl), .irq_lvl(irq_lvl), .vint_flag(vint_flag),
  .tgt_lvl(tgt_lvl), .h_pend(h_pend));

// File: tb/sim_vid_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vid_irq_ctrl;
  localparam int LAT = 4;
  localparam int NV  = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [4:0] reg_addr;
  logic [7:0] reg_data;
  logic       h_evt;
  logic [8:0] line_num;
  logic       ack_vld;
  logic [2:0] ack_lvl;
  logic [2:0] irq_lvl;
  logic       vint_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  vid_irq_ctrl #(.LAT_CYCLES(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_data(reg_data), .h_evt(h_evt), .line_num(line_num),
    .ack_vld(ack_vld), .ack_lvl(ack_lvl), .irq_lvl(irq_lvl), .vint_flag(vint_flag));

  // ops: 0 idle, 1 write addr0, 2 write addr1, 3 strobe line 10,
  //      4 strobe line 224, 5 ack level 4, 6 ack level 6, 7 write addr2
  // entry = {op, data, expected level, expected flag}
  localparam logic [14:0] VEC [NV] = '{
    {3'd3, 8'h00, 3'd0, 1'b0},  // R2 R6 pending while masked
    {3'd1, 8'h10, 3'd4, 1'b0},  // R2 enable raises level 4
    {3'd1, 8'hEF, 3'd0, 1'b0},  // R1 R5 other bits set, bit4 clear
    {3'd1, 8'h10, 3'd4, 1'b0},  // R6 pending survived mask
    {3'd7, 8'hFF, 3'd4, 1'b0},  // R1 foreign address ignored
    {3'd4, 8'h00, 3'd4, 1'b1},  // R3 flag set while vertical masked
    {3'd2, 8'h20, 3'd6, 1'b1},  // R4 both pending, vertical wins
    {3'd6, 8'h00, 3'd4, 1'b0},  // R7 vertical ack keeps horizontal
    {3'd5, 8'h00, 3'd0, 1'b0},  // R8 horizontal ack
    {3'd2, 8'hDF, 3'd0, 1'b0},  // R1 vertical enable off
    {3'd4, 8'h00, 3'd4, 1'b1},  // R3 flag regardless of enable
    {3'd5, 8'h00, 3'd0, 1'b1},  // R8 not armed: vertical kept
    {3'd2, 8'h20, 3'd6, 1'b1},  // R6 re-enable raises level 6
    {3'd5, 8'h00, 3'd0, 1'b0},  // R9 late horizontal ack drops vertical
    {3'd3, 8'h00, 3'd4, 1'b0},  // R2 strobe again
    {3'd1, 8'h00, 3'd0, 1'b0}   // R5 mask returns level to 0
  };

  task automatic check(input string req, input logic [2:0] el, input logic ef);
    checks++;
    if (irq_lvl !== el || vint_flag !== ef) begin
      fails++;
      $display("FAIL %s: irq_lvl=%0d vint_flag=%0b expected irq_lvl=%0d vint_flag=%0b",
               req, irq_lvl, vint_flag, el, ef);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    case (op)
      3'd1: begin reg_wr = 1; reg_addr = 5'd0; reg_data = d; end
      3'd2: begin reg_wr = 1; reg_addr = 5'd1; reg_data = d; end
      3'd3: begin h_evt = 1; line_num = 9'd10; end
      3'd4: begin h_evt = 1; line_num = 9'd224; end
      3'd5: begin ack_vld = 1; ack_lvl = 3'd4; end
      3'd6: begin ack_vld = 1; ack_lvl = 3'd6; end
      3'd7: begin reg_wr = 1; reg_addr = 5'd2; reg_data = d; end
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 0; reg_addr = '0; reg_data = '0;
    h_evt = 0; line_num = '0; ack_vld = 0; ack_lvl = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit held;
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_data = '0;
    h_evt = 0; line_num = '0; ack_vld = 0; ack_lvl = '0;
    repeat (3) @(negedge clk);
    check("R11 reset state", 3'd0, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][14:12], VEC[i][11:4]);
      repeat (LAT + 1) @(negedge clk);
      check($sformatf("vector %0d (R1..R9 per table)", i), VEC[i][3:1], VEC[i][0]);
    end

    // R10 exact latency: horizontal still pending, enable it
    do_op(3'd1, 8'h10);
    repeat (LAT) @(negedge clk);
    check("R10 level not yet changed", 3'd0, 1'b0);
    @(negedge clk);
    check("R10 level changed after latency", 3'd4, 1'b0);

    // R10 restart: quick off/on never disturbs the output
    do_op(3'd1, 8'h00);
    do_op(3'd1, 8'h10);
    held = 1;
    for (int k = 0; k < LAT + 4; k++) begin
      if (irq_lvl !== 3'd4) held = 0;
      @(negedge clk);
    end
    checks++;
    if (!held) begin
      fails++;
      $display("FAIL R10 restart: irq_lvl left 4 expected 4 throughout");
    end

    // R3 R4 vertical event with both enabled
    do_op(3'd4, 8'h00);
    repeat (LAT + 1) @(negedge clk);
    check("R3 R4 vertical over horizontal", 3'd6, 1'b1);

    // R11 mid-run reset
    rst_n = 0;
    @(negedge clk);
    check("R11 reset clears outputs", 3'd0, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    do_op(3'd2, 8'h20);
    repeat (LAT + 1) @(negedge clk);
    check("R11 pending cleared by reset", 3'd0, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule